// File: doc/BRIEF.md
# Pointer-Addressed I2C Control Register Slave

This block is an I2C target that lets a bus master read and write a small bank of 8-bit control registers. The device answers a 7-bit address whose top six bits are fixed and whose lowest bit follows a strap input, so two copies can share one bus. Every transfer works through an internal pointer: the first byte of a write transfer sets the pointer, and any later bytes in that transfer are stored into the registers. A read transfer needs no pointer phase. It starts returning the register the pointer currently selects straight after the address acknowledge.

The pointer byte carries a step flag in its top bit. While the flag is set, the pointer moves to the next register after each byte, so a burst covers consecutive registers and wraps at the end of the bank. While the flag is clear, the pointer stays put. SCL and SDA are taken in as ordinary inputs through two-flop synchronizers. SDA is driven as an open-drain enable, and that enable only changes just after SCL falls. The whole register bank is also presented on a flat output bus so the rest of the chip can use the settings.

Top module: `i2c_regport`

## Requirements
- R1: The device acknowledges an address byte whose bits 7..2 are 100110 and whose bit 1 equals `strap_i`. Bit 0 selects the direction, 1 meaning read. The acknowledge is given by holding SDA low during the ninth clock.
- R2: An address byte that does not match gets no acknowledge. All traffic after it is ignored, with no register change and no SDA drive, until the next START.
- R3: The first byte after the acknowledge of a write address is loaded into the pointer and not into a register. Bit 7 is the step flag and bits 2..0 are the register index. Each pointer byte and data byte is acknowledged.
- R4: Each further byte of a write transfer is stored in the register at the pointer index. Afterwards the index advances by one, modulo 8, if the step flag is 1, and stays the same if it is 0. The pointer keeps its value across transfers.
- R5: In a read transfer the byte sent straight after the address acknowledge is the register at the current pointer index, most significant bit first.
- R6: If a read is the first transfer after reset, it returns register 1, because the pointer resets to index 1 with the step flag 0.
- R7: While the master acknowledges each read byte, the device keeps sending. With the step flag at 1 it sends successive registers, wrapping from 7 to 0. With the step flag at 0 it sends the same register again.
- R8: After a master NACK on a read byte the device releases SDA and stays silent until a STOP or a START. The pointer does not advance for the byte that was not acknowledged.
- R9: `sda_oe_o` changes only in the cycle after a synchronized SCL falling edge, or when a START or STOP is seen, where it goes low. It is therefore stable across each SCL high phase.
- R10: After reset `sda_oe_o` is 0 and register i holds 0xA0 + i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_i | input | 1 | Address strap, compared with address bit 1 |
| scl_i | input | 1 | Bus clock level, asynchronous |
| sda_i | input | 1 | Bus data level, asynchronous |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| regs_o | output | NREG*8 | All registers, register i at bits [8i+7:8i] |

## Verification
On every cycle, the in-line properties check several things. The SDA enable moves only after an SCL fall, and it drops to released when a START or STOP arrives. A START always returns the transfer logic to address reception. A mismatched address keeps SDA released. A master NACK leaves the line released. Each pointer load and register write takes the value just shifted in. Which register a read returns, how the pointer steps and wraps across bursts, the reset-default pointer, and whether the pointer persists between transfers can only be shown by the bench scenarios, which compare bus-level bytes and acknowledges against expected values.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;

  localparam logic [5:0] DEV_PREFIX = 6'b100110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK,
    ST_IGNORE
  } xfer_state_e;

  // Address byte: prefix in [7:2], strap in [1], direction in [0]
  function automatic logic addr_hit(input logic [7:0] b, input logic strap);
    return (b[7:2] == DEV_PREFIX) && (b[1] == strap);
  endfunction

  // Reset content of register i
  function automatic logic [7:0] reg_reset_value(input int unsigned i);
    return 8'hA0 + 8'(i);
  endfunction

endpackage

// File: rtl/i2c_regport_sync.sv
module i2c_regport_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], din[b]};
    end
    assign dout[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2c_regport_events.sv
module i2c_regport_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

  p_events_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_rise, scl_fall, start_ev, stop_ev}));
endmodule

// File: rtl/i2c_regport_bank.sv
module i2c_regport_bank
  import i2c_regport_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [7:0]        wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [7:0]        rdata,
  output logic [NREG*8-1:0] regs_flat
);
  logic [7:0] regs_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            regs_q[i] <= reg_reset_value(i);
      else if (we && widx == IDX_W'(i))      regs_q[i] <= wdata;
    end
    assign regs_flat[i*8 +: 8] = regs_q[i];
  end

  assign rdata = regs_q[ridx];

  p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> regs_q[$past(widx)] == $past(wdata));
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
  import i2c_regport_pkg::*;
#(
  parameter int NREG        = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DEFAULT_IDX = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [NREG*8-1:0] regs_o
);
  localparam int IDX_W = $clog2(NREG);

  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  i2c_regport_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({scl_i, sda_i}), .dout({scl_s, sda_s})
  );

  i2c_regport_events u_ev (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  xfer_state_e      state;
  logic [3:0]       cnt;
  logic [7:0]       shreg;
  logic [7:0]       txsh;
  logic             ptr_phase;
  logic             ack_seen;
  logic             map_incr;
  logic [IDX_W-1:0] map_idx;
  logic             oe;

  // Named internal events
  logic             byte_done;
  logic             ptr_load;
  logic             wr_en;
  logic [IDX_W-1:0] rd_idx;
  logic [7:0]       rd_data;

  assign byte_done = (state == ST_WR_BYTE) && scl_fall && (cnt == 4'd8);
  assign ptr_load  = byte_done && ptr_phase;
  assign wr_en     = byte_done && !ptr_phase;
  assign rd_idx    = (state == ST_RD_ACK && map_incr) ? map_idx + IDX_W'(1) : map_idx;

  i2c_regport_bank #(.NREG(NREG), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .widx(map_idx), .wdata(shreg),
    .ridx(rd_idx), .rdata(rd_data), .regs_flat(regs_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      txsh      <= '0;
      ptr_phase <= 1'b0;
      ack_seen  <= 1'b0;
      map_incr  <= 1'b0;
      map_idx   <= IDX_W'(DEFAULT_IDX);
      oe        <= 1'b0;
    end else if (start_ev) begin
      state <= ST_ADDR;
      cnt   <= '0;
      oe    <= 1'b0;
    end else if (stop_ev) begin
      state <= ST_IDLE;
      oe    <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (scl_rise) begin
            shreg <= {shreg[6:0], sda_s};
            cnt   <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            if (addr_hit(shreg, strap_i)) begin
              oe    <= 1'b1;
              state <= ST_ADDR_ACK;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (shreg[0]) begin
              txsh  <= rd_data;
              oe    <= ~rd_data[7];
              state <= ST_RD_BYTE;
            end else begin
              oe        <= 1'b0;
              ptr_phase <= 1'b1;
              state     <= ST_WR_BYTE;
            end
          end
        end
        ST_WR_BYTE: begin
          if (scl_rise) begin
            shreg <= {shreg[6:0], sda_s};
            cnt   <= cnt + 4'd1;
          end else if (byte_done) begin
            oe    <= 1'b1;
            state <= ST_WR_ACK;
            if (ptr_phase) begin
              ptr_phase <= 1'b0;
              map_incr  <= shreg[7];
              map_idx   <= shreg[IDX_W-1:0];
            end else if (map_incr) begin
              map_idx <= map_idx + IDX_W'(1);
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            oe    <= 1'b0;
            cnt   <= '0;
            state <= ST_WR_BYTE;
          end
        end
        ST_RD_BYTE: begin
          if (scl_fall) begin
            if (cnt == 4'd7) begin
              oe    <= 1'b0;
              state <= ST_RD_ACK;
            end else begin
              oe   <= ~txsh[6];
              txsh <= {txsh[6:0], 1'b0};
              cnt  <= cnt + 4'd1;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            ack_seen <= ~sda_s;
          end else if (scl_fall) begin
            if (ack_seen) begin
              map_idx <= rd_idx;
              txsh    <= rd_data;
              oe      <= ~rd_data[7];
              cnt     <= '0;
              state   <= ST_RD_BYTE;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe;

  // Assertions beside the control logic
  p_drive_after_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> $past(scl_fall));

  p_oe_moves_on_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> $past(scl_fall || start_ev || stop_ev));

  p_start_to_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> state == ST_ADDR && !sda_oe_o);

  p_ignore_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_IGNORE |-> !sda_oe_o);

  p_ptr_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |=> map_incr == $past(shreg[7]) && map_idx == $past(shreg[IDX_W-1:0]));

  p_nack_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD_ACK && scl_fall && !ack_seen && !start_ev && !stop_ev)
      |=> state == ST_IGNORE && !sda_oe_o);
endmodule

// File: tb/i2c_regport_tb.sv
module i2c_regport_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b1;
  logic scl = 1'b1;
  logic sda_drv = 1'b1;
  logic sda_oe;
  logic [63:0] regs;
  logic sda_line;

  always #4 clk = ~clk;  // 125 MHz

  assign sda_line = sda_drv & ~sda_oe;

  i2c_regport u_dut (
    .clk(clk), .rst_n(rst_n), .strap_i(strap), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .regs_o(regs)
  );

  typedef struct { string req; int val; } item_t;
  item_t exp_q[$];
  int    obs_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  task automatic expect_item(input string req, input int val);
    exp_q.push_back('{req, val});
  endtask

  task automatic observe(input int val);
    obs_q.push_back(val);
  endtask

  // Monitor: pops observed results and compares with scoreboard
  always @(negedge clk) begin
    while (obs_q.size() > 0 && exp_q.size() > 0) begin
      item_t e;
      int    o;
      e = exp_q.pop_front();
      o = obs_q.pop_front();
      n_cmp++;
      if (o != e.val) begin
        n_bad++;
        $display("FAIL %s: actual 0x%0h expected 0x%0h", e.req, o, e.val);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; tick(4);
    scl = 1'b1;     tick(8);
    sda_drv = 1'b0; tick(8);
    scl = 1'b0;     tick(4);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; tick(4);
    scl = 1'b1;     tick(8);
    sda_drv = 1'b1; tick(8);
  endtask

  task automatic put_bit(input logic b);
    tick(4); sda_drv = b; tick(4);
    scl = 1'b1; tick(8);
    scl = 1'b0;
  endtask

  task automatic get_bit(output logic b, output logic steady);
    logic early;
    tick(4); sda_drv = 1'b1; tick(4);
    scl = 1'b1; tick(1);
    early = sda_line; tick(6);
    b = sda_line; steady = (early == b); tick(1);
    scl = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] v, output logic ack, output logic steady);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(ack, steady);
  endtask

  task automatic rd_byte(output logic [7:0] v, input logic ack_bit);
    logic s;
    for (int i = 7; i >= 0; i--) get_bit(v[i], s);
    put_bit(ack_bit);
  endtask

  function automatic logic [7:0] rst_val(input int i);
    return 8'(160 + i);
  endfunction

  function automatic logic [7:0] dev_addr(input logic strap_bit, input logic rd);
    return {6'b100110, strap_bit, rd};
  endfunction

  function automatic logic [7:0] reg_of(input int i);
    return regs[i*8 +: 8];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual expired expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic ack, st;
    logic [7:0] b;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R10: reset state
    expect_item("R10 oe", 0); observe(int'(sda_oe));
    for (int i = 0; i < 8; i++) begin
      expect_item("R10 reg", int'(rst_val(i))); observe(int'(reg_of(i)));
    end

    // R6/R5/R1/R8: first operation is a read
    bus_start();
    wr_byte(dev_addr(1'b1, 1'b1), ack, st);
    expect_item("R1 read addr ack", 0); observe(int'(ack));
    expect_item("R9 ack stable in high phase", 1); observe(int'(st));
    rd_byte(b, 1'b1);
    expect_item("R6 default pointer read", int'(rst_val(1))); observe(int'(b));
    rd_byte(b, 1'b1);
    expect_item("R8 silent after NACK", 8'hFF); observe(int'(b));
    bus_stop();

    // R3/R4: write with step flag, pointer to 3
    bus_start();
    wr_byte(dev_addr(1'b1, 1'b0), ack, st);
    expect_item("R1 write addr ack", 0); observe(int'(ack));
    wr_byte(8'h83, ack, st);
    expect_item("R3 pointer ack", 0); observe(int'(ack));
    expect_item("R3 pointer not stored", int'(rst_val(3))); observe(int'(reg_of(3)));
    wr_byte(8'h11, ack, st);
    expect_item("R4 data ack", 0); observe(int'(ack));
    wr_byte(8'h22, ack, st);
    expect_item("R4 data ack", 0); observe(int'(ack));
    bus_stop();
    expect_item("R4 reg3", 8'h11); observe(int'(reg_of(3)));
    expect_item("R4 reg4 stepped", 8'h22); observe(int'(reg_of(4)));

    // R7/R4: read burst continues from stepped pointer 5, wraps to 0
    bus_start();
    wr_byte(dev_addr(1'b1, 1'b1), ack, st);
    expect_item("R1 read addr ack", 0); observe(int'(ack));
    for (int k = 0; k < 4; k++) begin
      rd_byte(b, (k == 3));
      expect_item("R7 burst read", int'(rst_val((5 + k) % 8))); observe(int'(b));
    end
    bus_stop();

    // R4 without step flag, then R7 repeat read of same register
    bus_start();
    wr_byte(dev_addr(1'b1, 1'b0), ack, st);
    wr_byte(8'h02, ack, st);
    wr_byte(8'h55, ack, st);
    wr_byte(8'h66, ack, st);
    bus_start();
    wr_byte(dev_addr(1'b1, 1'b1), ack, st);
    expect_item("R1 repeated start read ack", 0); observe(int'(ack));
    rd_byte(b, 1'b0);
    expect_item("R5 read at pointer", 8'h66); observe(int'(b));
    rd_byte(b, 1'b1);
    expect_item("R7 no-step repeat", 8'h66); observe(int'(b));
    bus_stop();
    expect_item("R4 reg3 untouched", 8'h11); observe(int'(reg_of(3)));

    // R2: mismatched address (strap bit wrong)
    bus_start();
    wr_byte(dev_addr(1'b0, 1'b0), ack, st);
    expect_item("R2 no ack", 1); observe(int'(ack));
    wr_byte(8'h80, ack, st);
    expect_item("R2 ignored byte no ack", 1); observe(int'(ack));
    wr_byte(8'h77, ack, st);
    bus_stop();
    expect_item("R2 reg0 unchanged", int'(rst_val(0))); observe(int'(reg_of(0)));

    // R1: strap low now matches address bit 1 = 0
    strap = 1'b0;
    tick(4);
    bus_start();
    wr_byte(dev_addr(1'b0, 1'b0), ack, st);
    expect_item("R1 strap low ack", 0); observe(int'(ack));
    wr_byte(8'h80, ack, st);
    wr_byte(8'h12, ack, st);
    bus_stop();
    expect_item("R4 reg0 written", 8'h12); observe(int'(reg_of(0)));

    tick(4);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule